// File: doc/BRIEF.md
# Sequencer Instruction Memory Load Path

This block is the host-side path for loading the instruction store of a small embedded sequencer. The store holds 32-bit words and is addressed by word. The host has three ports into it: an 8-bit control register, a 9-bit word pointer, and a byte-wide data port. Each byte written to the data port goes straight into one byte lane of the word the pointer selects. The pointer moves to the next word only after the top lane has been written.

A parity bit is kept for each word and is refreshed whenever the top lane is written. A fetch port stands in for the sequencer's execution datapath. A fetch returns the word one cycle after the request and recomputes its parity. On a mismatch the fetch raises a sticky parity error, unless checking has been disabled or loading is enabled. Accesses beyond the implemented depth raise a sticky illegal-address flag. The reset bit in the control register pauses the sequencer and pins the pointer at zero.

Top module: `seq_ram_loader`

## Requirements
- R1: After rst_ni is asserted, ctrl_o, addr_o, lane_o, err_o, fetch_valid_o and fetch_data_o are all zero.
- R2: An accepted data write to lanes 0 to 2 advances lane_o by one and leaves addr_o unchanged. An accepted write to lane 3 returns lane_o to 0 and increments addr_o, so that 511 wraps to 0.
- R3: A control write with bit 1 set clears addr_o and lane_o at that edge. While control bit 1 stays set, addr_o and lane_o remain 0, address and data writes are ignored, and paused_o is 1.
- R4: ctrl_o returns the last value written to the control register, with bit 5 always reading 0. Bit 0 is load enable, bit 1 is reset and bit 7 disables parity checking; bits 2, 3, 4 and 6 are stored only.
- R5: A data write is ignored unless pause_i is 1 and control bit 0 is 1. An ignored write leaves addr_o, lane_o and the memory contents unchanged.
- R6: An address write takes effect only when pause_i is 1 and control bit 1 is 0. It sets addr_o and returns lane_o to 0. If an address write and a data write arrive in the same cycle, the address write takes effect and the data write is dropped.
- R7: A fetch requested in cycle t sets fetch_valid_o to 1 in cycle t+1. In that cycle fetch_data_o carries the stored word, with lane k in bits 8k+7:8k, or zero if the address is at or beyond DEPTH (448).
- R8: Each accepted data write updates its byte lane in the memory at once. The parity bit is written only with lane 3 and is the even parity over the whole 32-bit word as it then stands.
- R9: A fetch of an in-range word whose stored parity does not match its contents sets err_o bit 3 in the cycle its data is returned. This does not happen if control bit 7 or bit 0 was set in the request cycle.
- R10: A data write at an address of DEPTH or more leaves the memory unchanged but still steps the lane and pointer. Such a write, or a fetch of such an address, sets err_o bit 1.
- R11: err_o bits 3 and 1 stay set until rst_ni, and err_o bits 2 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pause_i | input | 1 | Host pause request; allows loading |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| addr_we_i | input | 1 | Word pointer write strobe |
| addr_wdata_i | input | 9 | Word pointer write data |
| data_we_i | input | 1 | Data port write strobe |
| data_wdata_i | input | 8 | Instruction byte |
| fetch_req_i | input | 1 | Fetch request from the sequencer stand-in |
| fetch_addr_i | input | 9 | Fetch word address |
| ctrl_o | output | 8 | Control register contents |
| addr_o | output | 9 | Current word pointer |
| lane_o | output | 2 | Next byte lane to be written |
| paused_o | output | 1 | Sequencer held (pause_i or reset bit) |
| fetch_valid_o | output | 1 | Fetch data valid |
| fetch_data_o | output | 32 | Fetched word |
| err_o | output | 4 | Sticky hard errors: bit 3 parity, bit 1 illegal address |

## Verification
The hardest case to reach is a real parity mismatch. No port can corrupt a stored word directly, so the mismatch has to be created by loading. The bench loads a full word, then rewrites only its low lane with a byte of different bit count, and moves the pointer before the top lane is written. This leaves stale parity behind. It then fetches that word three times: with load enable set, with the parity-disable bit set, and with checking active. This shows both kinds of suppression and then the error itself.

// File: rtl/seq_ld_pkg.sv
package seq_ld_pkg;
  localparam int CTL_LOAD    = 0;
  localparam int CTL_RST     = 1;
  localparam int CTL_STEP    = 2;
  localparam int CTL_BRKEN   = 3;
  localparam int CTL_FAST    = 4;
  localparam int CTL_PDIS    = 6;
  localparam int CTL_PERRDIS = 7;
  localparam logic [7:0] CTL_MASK = 8'hDF;

  localparam int ERR_PAR  = 3;
  localparam int ERR_OPC  = 2;
  localparam int ERR_ADDR = 1;
  localparam int ERR_HOST = 0;
endpackage

// File: rtl/seq_ld_regs.sv
module seq_ld_regs
  import seq_ld_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pause_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              data_we_i,
  output logic [7:0]        ctrl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              wr_fire_o
);
  logic [7:0]        ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] lane_q;
  logic clr, addr_ok, wr_fire, last_lane;

  // reset bit pending or held: pointer pinned, writes blocked
  assign clr       = ctrl_q[CTL_RST] | (ctrl_we_i & ctrl_wdata_i[CTL_RST]);
  assign addr_ok   = addr_we_i & pause_i & ~clr;
  assign wr_fire   = data_we_i & pause_i & ctrl_q[CTL_LOAD] & ~clr & ~addr_we_i;
  assign last_lane = &lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & CTL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      lane_q <= '0;
    end else if (clr) begin
      addr_q <= '0;
      lane_q <= '0;
    end else if (addr_ok) begin
      addr_q <= addr_wdata_i;
      lane_q <= '0;
    end else if (wr_fire) begin
      if (last_lane) begin
        lane_q <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign addr_o    = addr_q;
  assign lane_o    = lane_q;
  assign wr_fire_o = wr_fire;

  a_r3_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTL_RST] |-> (addr_q == '0 && lane_q == '0));

  a_r2_lane_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && !last_lane) |=> (lane_q == LANE_W'($past(lane_q) + 1'b1)) && $stable(addr_q));

  a_r2_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && last_lane) |=> (lane_q == '0) && (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  a_r5_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_i && !ctrl_we_i && !ctrl_q[CTL_RST]) |=> $stable(addr_q) && $stable(lane_q));
endmodule

// File: rtl/seq_ld_mem.sv
module seq_ld_mem #(
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 448,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fire_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              perr_supp_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              perr_hit_o,
  output logic              ill_hit_o
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic              mem_p [DEPTH];

  logic              wr_in, rd_in, last_lane;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] cur_word, new_word, rd_word;
  logic              rd_par;
  logic              fv_q;
  logic [DATA_W-1:0] fd_q;

  assign wr_in     = {1'b0, wr_addr_i} < DEPTH_V;
  assign rd_in     = {1'b0, fetch_addr_i} < DEPTH_V;
  assign wr_idx    = wr_addr_i[IDX_W-1:0];
  assign rd_idx    = fetch_addr_i[IDX_W-1:0];
  assign last_lane = &wr_lane_i;
  assign cur_word  = mem_d[wr_idx];
  assign rd_word   = mem_d[rd_idx];
  assign rd_par    = mem_p[rd_idx];

  // merge incoming byte into its lane of the addressed word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign new_word[g*BYTE_W +: BYTE_W] =
      (wr_lane_i == LANE_W'(g)) ? wr_byte_i : cur_word[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i) begin
    if (wr_fire_i && wr_in) begin
      mem_d[wr_idx] <= new_word;
      if (last_lane) mem_p[wr_idx] <= ^new_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_q <= 1'b0;
      fd_q <= '0;
    end else begin
      fv_q <= fetch_req_i;
      if (fetch_req_i) fd_q <= rd_in ? rd_word : '0;
    end
  end

  assign perr_hit_o    = fetch_req_i & rd_in & ~perr_supp_i & (^{rd_word, rd_par});
  assign ill_hit_o     = (wr_fire_i & ~wr_in) | (fetch_req_i & ~rd_in);
  assign fetch_valid_o = fv_q;
  assign fetch_data_o  = fd_q;

  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i |=> fetch_valid_o);

  a_r10_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !rd_in) |=> (fetch_data_o == '0));
endmodule

// File: rtl/seq_ld_err.sv
module seq_ld_err
  import seq_ld_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       perr_hit_i,
  input  logic       ill_hit_i,
  output logic [3:0] err_o
);
  logic par_q, ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      par_q <= par_q | perr_hit_i;
      ill_q <= ill_q | ill_hit_i;
    end
  end

  always_comb begin
    err_o           = '0;
    err_o[ERR_PAR]  = par_q;
    err_o[ERR_ADDR] = ill_q;
  end

  a_r11_par_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_q |=> par_q);

  a_r11_addr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_q |=> ill_q);
endmodule

// File: rtl/seq_ram_loader.sv
module seq_ram_loader
  import seq_ld_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 448,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANE_W = $clog2(DATA_W / BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pause_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              data_we_i,
  input  logic [BYTE_W-1:0] data_wdata_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [7:0]        ctrl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              paused_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic [3:0]        err_o
);
  logic wr_fire, perr_hit, ill_hit, perr_supp;

  seq_ld_regs #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pause_i      (pause_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .addr_we_i    (addr_we_i),
    .addr_wdata_i (addr_wdata_i),
    .data_we_i    (data_we_i),
    .ctrl_o       (ctrl_o),
    .addr_o       (addr_o),
    .lane_o       (lane_o),
    .wr_fire_o    (wr_fire)
  );

  // loading or explicit disable masks parity checks
  assign perr_supp = ctrl_o[CTL_PERRDIS] | ctrl_o[CTL_LOAD];
  assign paused_o  = pause_i | ctrl_o[CTL_RST];

  seq_ld_mem #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANE_W(LANE_W)
  ) u_mem (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_fire_i     (wr_fire),
    .wr_addr_i     (addr_o),
    .wr_lane_i     (lane_o),
    .wr_byte_i     (data_wdata_i),
    .perr_supp_i   (perr_supp),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .fetch_valid_o (fetch_valid_o),
    .fetch_data_o  (fetch_data_o),
    .perr_hit_o    (perr_hit),
    .ill_hit_o     (ill_hit)
  );

  seq_ld_err u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .perr_hit_i (perr_hit),
    .ill_hit_i  (ill_hit),
    .err_o      (err_o)
  );

  a_r9_perr_at_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[ERR_PAR]) |-> fetch_valid_o);

  a_r3_reset_bit_pauses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[CTL_RST]) |=> (paused_o && addr_o == '0));
endmodule

// File: tb/seq_ram_loader_tb_top.sv
module seq_ram_loader_tb_top;
  localparam int DEPTH = 448;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pause = 1'b0;
  logic       cwe = 1'b0, awe = 1'b0, dwe = 1'b0, fr = 1'b0;
  logic [7:0] cw = '0, dw = '0;
  logic [8:0] aw = '0, fa = '0;

  logic [7:0]  ctrl_o;
  logic [8:0]  addr_o;
  logic [1:0]  lane_o;
  logic        paused_o, fetch_valid_o;
  logic [31:0] fetch_data_o;
  logic [3:0]  err_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seq_ram_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pause_i(pause),
    .ctrl_we_i(cwe), .ctrl_wdata_i(cw),
    .addr_we_i(awe), .addr_wdata_i(aw),
    .data_we_i(dwe), .data_wdata_i(dw),
    .fetch_req_i(fr), .fetch_addr_i(fa),
    .ctrl_o(ctrl_o), .addr_o(addr_o), .lane_o(lane_o), .paused_o(paused_o),
    .fetch_valid_o(fetch_valid_o), .fetch_data_o(fetch_data_o), .err_o(err_o)
  );

  // behavioural reference
  logic [7:0]  rb [0:511][0:3];
  logic        rp [0:511];
  logic [7:0]  m_ctrl;
  logic [8:0]  m_addr;
  logic [1:0]  m_lane;
  logic [3:0]  m_err;
  logic        m_fv;
  logic [31:0] m_fd;

  function automatic logic [31:0] word_of(input logic [8:0] a);
    return {rb[a][3], rb[a][2], rb[a][1], rb[a][0]};
  endfunction

  initial begin
    for (int i = 0; i < 512; i++) begin
      rp[i] = 1'b0;
      for (int j = 0; j < 4; j++) rb[i][j] = 8'h00;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    logic clr, wr;
    logic [31:0] w;
    if (!rst_n) begin
      m_ctrl = '0; m_addr = '0; m_lane = '0; m_err = '0; m_fv = 1'b0; m_fd = '0;
    end else begin
      m_fv = fr;
      if (fr) begin
        if (fa < DEPTH) begin
          w = word_of(fa);
          m_fd = w;
          if (!(m_ctrl[7] | m_ctrl[0]) && ((^w) != rp[fa])) m_err[3] = 1'b1;
        end else begin
          m_fd = '0;
          m_err[1] = 1'b1;
        end
      end
      clr = m_ctrl[1] | (cwe & cw[1]);
      wr  = dwe & pause & m_ctrl[0] & ~clr & ~awe;
      if (wr) begin
        if (m_addr < DEPTH) begin
          rb[m_addr][m_lane] = dw;
          if (m_lane == 2'd3) rp[m_addr] = ^word_of(m_addr);
        end else m_err[1] = 1'b1;
      end
      if (clr) begin
        m_addr = '0; m_lane = '0;
      end else if (awe && pause) begin
        m_addr = aw; m_lane = '0;
      end else if (wr) begin
        if (m_lane == 2'd3) begin m_lane = '0; m_addr = m_addr + 9'd1; end
        else m_lane = m_lane + 2'd1;
      end
      if (cwe) m_ctrl = cw & 8'hDF;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (cmp_on && !done) begin
      chk("R4 ctrl_o", {24'd0, ctrl_o}, {24'd0, m_ctrl});
      chk("R2 addr_o", {23'd0, addr_o}, {23'd0, m_addr});
      chk("R2 lane_o", {30'd0, lane_o}, {30'd0, m_lane});
      chk("R3 paused_o", {31'd0, paused_o}, {31'd0, pause | m_ctrl[1]});
      chk("R7 fetch_valid_o", {31'd0, fetch_valid_o}, {31'd0, m_fv});
      chk("R7 fetch_data_o", fetch_data_o, m_fd);
      chk("R9 err_o[3]", {31'd0, err_o[3]}, {31'd0, m_err[3]});
      chk("R10 err_o[1]", {31'd0, err_o[1]}, {31'd0, m_err[1]});
      chk("R11 err_o[2,0]", {30'd0, err_o[2], err_o[0]}, 32'd0);
    end
  end

  task automatic op(input logic a_cwe, input logic [7:0] a_cw, input logic a_awe,
                    input logic [8:0] a_aw, input logic a_dwe, input logic [7:0] a_dw,
                    input logic a_fr, input logic [8:0] a_fa);
    @(negedge clk);
    cwe = a_cwe; cw = a_cw; awe = a_awe; aw = a_aw;
    dwe = a_dwe; dw = a_dw; fr = a_fr; fa = a_fa;
  endtask

  task automatic idle();              op(0, 8'h0, 0, 9'h0, 0, 8'h0, 0, 9'h0); endtask
  task automatic wctrl(input logic [7:0] v); op(1, v, 0, 9'h0, 0, 8'h0, 0, 9'h0); endtask
  task automatic waddr(input logic [8:0] a); op(0, 8'h0, 1, a, 0, 8'h0, 0, 9'h0); endtask
  task automatic wbyte(input logic [7:0] b); op(0, 8'h0, 0, 9'h0, 1, b, 0, 9'h0); endtask
  task automatic fetch(input logic [8:0] a); op(0, 8'h0, 0, 9'h0, 0, 8'h0, 1, a); endtask
  task automatic set_pause(input logic p);
    @(negedge clk);
    pause = p; cwe = 0; awe = 0; dwe = 0; fr = 0;
  endtask
  task automatic wword(input logic [31:0] w);
    for (int k = 0; k < 4; k++) wbyte(w[k*8 +: 8]);
  endtask
  task automatic settle(); idle(); #2; endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    settle();
    // R1 reset state
    chk("R1 ctrl", {24'd0, ctrl_o}, 32'd0);
    chk("R1 addr/lane", {21'd0, addr_o, lane_o}, 32'd0);
    chk("R1 err", {28'd0, err_o}, 32'd0);
    chk("R1 fetch", {fetch_data_o[30:0], fetch_valid_o}, 32'd0);

    // load two words
    set_pause(1);
    wctrl(8'h01);
    waddr(9'd16);
    wword(32'h44332211);
    wword(32'h005AFFA5);
    settle();
    chk("R2 addr after two words", {23'd0, addr_o}, 32'd18);

    // R5 ignored writes
    set_pause(0);
    wbyte(8'h99);
    settle();
    chk("R5 no pause lane", {30'd0, lane_o}, 32'd0);
    set_pause(1);
    wctrl(8'h00);
    wbyte(8'h99);
    settle();
    chk("R5 no load lane", {21'd0, addr_o, lane_o}, {21'd0, 9'd18, 2'd0});
    fetch(9'd16);
    settle();
    chk("R5 R8 word16", fetch_data_o, 32'h44332211);
    chk("R8 good parity", {31'd0, err_o[3]}, 32'd0);
    fetch(9'd17);
    settle();
    chk("R7 word17", fetch_data_o, 32'h005AFFA5);

    // R6 address wins over data
    wctrl(8'h01);
    op(0, 8'h0, 1, 9'd5, 1, 8'h66, 0, 9'h0);
    settle();
    chk("R6 addr wins", {21'd0, addr_o, lane_o}, {21'd0, 9'd5, 2'd0});
    set_pause(0);
    waddr(9'd7);
    settle();
    chk("R6 addr ignored unpaused", {23'd0, addr_o}, 32'd5);
    set_pause(1);

    // stale parity from an abandoned word
    waddr(9'd16);
    wbyte(8'h10);
    waddr(9'd100);
    fetch(9'd16);
    settle();
    chk("R8 lane written at once", fetch_data_o, 32'h44332210);
    chk("R9 suppressed by load", {31'd0, err_o[3]}, 32'd0);
    wctrl(8'h80);
    fetch(9'd16);
    settle();
    chk("R9 suppressed by disable", {31'd0, err_o[3]}, 32'd0);
    wctrl(8'h00);
    fetch(9'd16);
    settle();
    chk("R9 parity error", {31'd0, err_o[3]}, 32'd1);

    // R10 illegal address, R2 wrap
    wctrl(8'h01);
    waddr(9'd447);
    wword(32'hEFBEADDE);
    settle();
    chk("R2 addr 448", {23'd0, addr_o}, 32'd448);
    wbyte(8'h77);
    settle();
    chk("R10 oob write flag", {31'd0, err_o[1]}, 32'd1);
    chk("R10 oob lane steps", {30'd0, lane_o}, 32'd1);
    fetch(9'd500);
    settle();
    chk("R10 oob fetch zero", fetch_data_o, 32'd0);
    waddr(9'd511);
    wword(32'h04030201);
    settle();
    chk("R2 wrap to 0", {23'd0, addr_o}, 32'd0);
    wctrl(8'h00);
    fetch(9'd447);
    settle();
    chk("R7 word447", fetch_data_o, 32'hEFBEADDE);
    fetch(9'd511);
    settle();
    chk("R10 word511 beyond depth", fetch_data_o, 32'd0);

    // R3 reset bit, R4 mask
    set_pause(0);
    wctrl(8'h03);
    settle();
    chk("R3 paused by reset bit", {31'd0, paused_o}, 32'd1);
    chk("R3 pointer cleared", {21'd0, addr_o, lane_o}, 32'd0);
    set_pause(1);
    waddr(9'd9);
    wbyte(8'h12);
    settle();
    chk("R3 writes blocked", {21'd0, addr_o, lane_o}, 32'd0);
    wctrl(8'hFF);
    settle();
    chk("R4 bit5 reads 0", {24'd0, ctrl_o}, 32'hDF);
    wctrl(8'h00);
    settle();

    // R11 sticky, then cleared by reset
    chk("R11 sticky bits", {28'd0, err_o}, 32'hA);
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk("R11 cleared by reset", {28'd0, err_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R1 reset again", {20'd0, ctrl_o, addr_o[3:0]}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule